// File: doc/BRIEF.md
# Oscillation Stabilization Wait Sequencer

This block decides when the device clock may be trusted after a reset or a wake-up. It moves the chip through a settings-reset state, a stabilization wait, an operation-reset hold and normal running. It also handles the path into and out of stop mode. The wait is timed by a down-counter. The counter is loaded once at the start of each wait, and the value loaded depends on why the wait began.

A release of the external init pin always uses the shortest interval. This is because the pin pulse itself is expected to cover oscillator start-up, and the pin also clears the programmed wait setting. An internal init request uses the interval software last programmed. A wake from stop uses the programmed interval if the oscillator halts in stop mode, stretched to the PLL lock time when the PLL is in use and its lock time is the longer of the two. If the oscillator keeps running through stop mode, the wake uses the shortest interval. After an init-caused wait, operation reset is held for a fixed number of cycles. After a stop-caused wait, the block returns straight to running.

Top module: `osc_wait_seq`

## Requirements
- R1: While `init_n` is low, `state` reads 0 (settings reset), and `clk_ready` and `op_rst` are both low.
- R2: After `init_n` rises, `state` reads 1 (stabilization wait) for exactly 2^TAP0_EXP cycles. This holds whatever value `wsel` carries, because the pin clears the latched setting to code 00.
- R3: When an init-caused wait ends, `state` reads 2 and `op_rst` is high for exactly OPRST_CYCLES cycles. Then `state` reads 3 (running) with `clk_ready` high and `op_rst` low.
- R4: An `int_init` pulse in any state other than 0 puts the block in state 0 for one cycle. A wait of 2^TAPk_EXP cycles follows, where k is the `wsel` code latched while running.
- R5: `wsel` is captured only in state 3. A change of `wsel` while in stop (state 4) has no effect on the wake-up wait.
- R6: A wake with `osc_stop_cfg`=1 and `pll_used`=1 waits for max(2^TAPk_EXP, 2^PLL_EXP) cycles.
- R7: A wake with `osc_stop_cfg`=1 and `pll_used`=0 waits for 2^TAPk_EXP cycles.
- R8: A wake with `osc_stop_cfg`=0 waits for 2^TAP0_EXP cycles, whatever the setting and the PLL flag.
- R9: A stop-caused wait goes straight to state 3 without passing through state 2.
- R10: A low level on `init_n` during a wait aborts it at once and returns the block to state 0. The next release then waits for the minimum interval.
- R11: `clk_ready` is high only in states 2 and 3. It is low in states 0, 1 and 4.
- R12: In state 3, `int_init` takes priority over `stop_req` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| init_n | input | 1 | External init pin, active low, asynchronous |
| int_init | input | 1 | Internal init request |
| stop_req | input | 1 | Request to enter stop mode |
| wake | input | 1 | Wake event that ends stop mode |
| wsel | input | 2 | Programmed wait-select code (00 = shortest) |
| osc_stop_cfg | input | 1 | 1 = source oscillator halts in stop mode |
| pll_used | input | 1 | 1 = PLL drives the source clock |
| state | output | 3 | 0 reset, 1 wait, 2 operation reset, 3 run, 4 stop |
| op_rst | output | 1 | Operation-reset hold |
| clk_ready | output | 1 | Clock is stable and usable |

## Verification
A wrong internal state appears directly on the `state` port. It is visible within one cycle of the wrong transition. The counter and the length selector have no direct port, so their faults appear only as a wait that is the wrong length. That error can only be seen when the wait ends: up to 2^TAP3_EXP cycles later, or early if the wait ends too soon. For this reason, every wait length is measured cycle by cycle, for each cause of entry. A setting that was latched wrongly shows only as a wrong length on the next wait that uses it. That may be several scenarios later, so the tests change `wsel` between the point of capture and the point of use.

// File: rtl/osw_pkg.sv
package osw_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_OSCW  = 3'd1,
    ST_OPRST = 3'd2,
    ST_RUN   = 3'd3,
    ST_STOP  = 3'd4
  } osw_state_e;

  typedef enum logic [1:0] {
    CAUSE_PIN  = 2'd0,
    CAUSE_SOFT = 2'd1,
    CAUSE_WAKE = 2'd2
  } osw_cause_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/osw_len_sel.sv
module osw_len_sel
  import osw_pkg::*;
#(
  parameter int TAP0_EXP = 11,
  parameter int TAP1_EXP = 14,
  parameter int TAP2_EXP = 16,
  parameter int TAP3_EXP = 18,
  parameter int PLL_EXP  = 15,
  parameter int CW       = 19
) (
  input  osw_cause_e      cause,
  input  logic [1:0]      wsel_q,
  input  logic            osc_stop_cfg,
  input  logic            pll_used,
  output logic [CW-1:0]   len_m1
);

  localparam int NTAPS = 4;
  localparam int TAPS [NTAPS] = '{TAP0_EXP, TAP1_EXP, TAP2_EXP, TAP3_EXP};
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] PLL_LEN = ONE << PLL_EXP;

  logic [CW-1:0] tap_len [NTAPS];
  logic [CW-1:0] osc_len;
  logic [CW-1:0] len;

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign tap_len[g] = ONE << TAPS[g];
  end

  assign osc_len = tap_len[wsel_q];

  always_comb begin
    unique case (cause)
      CAUSE_SOFT: len = osc_len;
      CAUSE_WAKE: begin
        if (!osc_stop_cfg)
          len = tap_len[0];
        else if (pll_used && (PLL_LEN > osc_len))
          len = PLL_LEN;
        else
          len = osc_len;
      end
      default:    len = tap_len[0];
    endcase
  end

  assign len_m1 = len - ONE;

endmodule

// File: rtl/osw_down_ctr.sv
module osw_down_ctr #(
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          init_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          done
);

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/osw_ctrl_fsm.sv
module osw_ctrl_fsm
  import osw_pkg::*;
#(
  parameter int CW           = 19,
  parameter int OPRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          init_n,
  input  logic          int_init,
  input  logic          stop_req,
  input  logic          wake,
  input  logic          done,
  input  logic [CW-1:0] wait_len_m1,
  output osw_state_e    state,
  output osw_cause_e    len_cause,
  output logic          load,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] OPRST_M1 = CW'(OPRST_CYCLES - 1);

  osw_state_e state_n;
  osw_cause_e cause_q, cause_n;

  assign len_cause = (state == ST_STOP) ? CAUSE_WAKE : cause_q;

  always_comb begin
    state_n  = state;
    cause_n  = cause_q;
    load     = 1'b0;
    load_val = wait_len_m1;
    unique case (state)
      ST_INIT: begin
        state_n = ST_OSCW;
        load    = 1'b1;
      end
      ST_OSCW: begin
        if (int_init) begin
          state_n = ST_INIT;
          cause_n = CAUSE_SOFT;
        end else if (done) begin
          if (cause_q == CAUSE_WAKE) begin
            state_n = ST_RUN;
          end else begin
            state_n  = ST_OPRST;
            load     = 1'b1;
            load_val = OPRST_M1;
          end
        end
      end
      ST_OPRST: begin
        if (int_init) begin
          state_n = ST_INIT;
          cause_n = CAUSE_SOFT;
        end else if (done) begin
          state_n = ST_RUN;
        end
      end
      ST_RUN: begin
        if (int_init) begin
          state_n = ST_INIT;
          cause_n = CAUSE_SOFT;
        end else if (stop_req) begin
          state_n = ST_STOP;
        end
      end
      ST_STOP: begin
        if (int_init) begin
          state_n = ST_INIT;
          cause_n = CAUSE_SOFT;
        end else if (wake) begin
          state_n = ST_OSCW;
          cause_n = CAUSE_WAKE;
          load    = 1'b1;
        end
      end
      default: begin
        state_n = ST_INIT;
        cause_n = CAUSE_PIN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      state   <= ST_INIT;
      cause_q <= CAUSE_PIN;
    end else begin
      state   <= state_n;
      cause_q <= cause_n;
    end
  end

endmodule

// File: rtl/osc_wait_seq.sv
module osc_wait_seq
  import osw_pkg::*;
#(
  parameter int TAP0_EXP     = 11,
  parameter int TAP1_EXP     = 14,
  parameter int TAP2_EXP     = 16,
  parameter int TAP3_EXP     = 18,
  parameter int PLL_EXP      = 15,
  parameter int OPRST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       init_n,
  input  logic       int_init,
  input  logic       stop_req,
  input  logic       wake,
  input  logic [1:0] wsel,
  input  logic       osc_stop_cfg,
  input  logic       pll_used,
  output logic [2:0] state,
  output logic       op_rst,
  output logic       clk_ready
);

  localparam int MAXE = imax(imax(imax(TAP0_EXP, TAP1_EXP), imax(TAP2_EXP, TAP3_EXP)),
                             imax(PLL_EXP, $clog2(OPRST_CYCLES)));
  localparam int CW = MAXE + 1;

  osw_state_e    st;
  osw_cause_e    len_cause;
  logic [1:0]    wsel_q;
  logic [CW-1:0] wait_len_m1;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          load;
  logic          done;

  // Wait-select latch: follows the programmed code only while running,
  // cleared to the shortest code by the init pin.
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)
      wsel_q <= 2'b00;
    else if (st == ST_RUN)
      wsel_q <= wsel;
  end

  osw_len_sel #(
    .TAP0_EXP(TAP0_EXP), .TAP1_EXP(TAP1_EXP), .TAP2_EXP(TAP2_EXP),
    .TAP3_EXP(TAP3_EXP), .PLL_EXP(PLL_EXP), .CW(CW)
  ) u_len (
    .cause        (len_cause),
    .wsel_q       (wsel_q),
    .osc_stop_cfg (osc_stop_cfg),
    .pll_used     (pll_used),
    .len_m1       (wait_len_m1)
  );

  osw_ctrl_fsm #(.CW(CW), .OPRST_CYCLES(OPRST_CYCLES)) u_fsm (
    .clk         (clk),
    .init_n      (init_n),
    .int_init    (int_init),
    .stop_req    (stop_req),
    .wake        (wake),
    .done        (done),
    .wait_len_m1 (wait_len_m1),
    .state       (st),
    .len_cause   (len_cause),
    .load        (load),
    .load_val    (load_val)
  );

  osw_down_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .init_n   (init_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .done     (done)
  );

  assign state     = st;
  assign op_rst    = (st == ST_OPRST);
  assign clk_ready = (st == ST_OPRST) || (st == ST_RUN);

endmodule

// File: rtl/osc_wait_seq_chk.sv
module osc_wait_seq_chk
  import osw_pkg::*;
#(
  parameter int CW = 19
) (
  input logic          clk,
  input logic          init_n,
  input logic [2:0]    state,
  input logic          op_rst,
  input logic          clk_ready,
  input logic [1:0]    wsel_q,
  input logic [CW-1:0] cnt
);

  // R1
  always_ff @(posedge clk) begin
    if (!init_n) begin
      init_hold_chk: assert (state == ST_INIT && !clk_ready && !op_rst);
    end
  end

  // R11
  ready_state_chk: assert property (@(posedge clk) disable iff (!init_n)
    clk_ready |-> (state == ST_OPRST || state == ST_RUN));

  // R3
  oprst_entry_chk: assert property (@(posedge clk) disable iff (!init_n)
    $rose(op_rst) |-> ($past(state) == ST_OSCW));

  // R9
  run_entry_chk: assert property (@(posedge clk) disable iff (!init_n)
    (state == ST_RUN && $past(state) != ST_RUN) |->
      ($past(state) == ST_OPRST || $past(state) == ST_OSCW));

  // R5
  wsel_hold_chk: assert property (@(posedge clk) disable iff (!init_n)
    (state == ST_STOP && $past(state) == ST_STOP) |-> $stable(wsel_q));

  // R2
  wait_end_chk: assert property (@(posedge clk) disable iff (!init_n)
    (state == ST_OSCW && cnt == '0) |=> (state != ST_OSCW));

endmodule

bind osc_wait_seq osc_wait_seq_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .init_n    (init_n),
  .state     (state),
  .op_rst    (op_rst),
  .clk_ready (clk_ready),
  .wsel_q    (wsel_q),
  .cnt       (cnt)
);

// File: tb/osc_wait_seq_test.sv
module osc_wait_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int T0 = 3, T1 = 5, T2 = 6, T3 = 7, TP = 6, OPR = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic init_n = 1'b0;
  logic int_init = 1'b0, stop_req = 1'b0, wake = 1'b0;
  logic [1:0] wsel = 2'b11;
  logic osc_stop_cfg = 1'b0, pll_used = 1'b0;
  logic [2:0] state;
  logic op_rst, clk_ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_wait_seq #(
    .TAP0_EXP(T0), .TAP1_EXP(T1), .TAP2_EXP(T2), .TAP3_EXP(T3),
    .PLL_EXP(TP), .OPRST_CYCLES(OPR)
  ) uut (
    .clk(clk), .init_n(init_n), .int_init(int_init), .stop_req(stop_req),
    .wake(wake), .wsel(wsel), .osc_stop_cfg(osc_stop_cfg), .pll_used(pll_used),
    .state(state), .op_rst(op_rst), .clk_ready(clk_ready)
  );

  function automatic int tap(int code);
    case (code)
      0: return 1 << T0;
      1: return 1 << T1;
      2: return 1 << T2;
      default: return 1 << T3;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges spent in state s; flags any cycle with the wrong ready level.
  task automatic count_in(input logic [2:0] s, input bit ready_exp,
                          output int n, output bit ready_bad);
    n = 0;
    ready_bad = 1'b0;
    while (state == s && n < 5000) begin
      if (clk_ready !== ready_exp) ready_bad = 1'b1;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic init_tail(string req, int exp_wait);
    int n;
    bit bad;
    chk(state == 3'd1, req, state, 1);
    count_in(3'd1, 1'b0, n, bad);
    chk(n == exp_wait, req, n, exp_wait);
    chk(!bad, "R11", bad, 0);
    chk(state == 3'd2 && op_rst, "R3", state, 2);
    count_in(3'd2, 1'b1, n, bad);
    chk(n == OPR, "R3", n, OPR);
    chk(state == 3'd3 && clk_ready && !op_rst, "R3", state, 3);
  endtask

  task automatic t_pin_init();
    @(negedge clk);
    init_n = 1'b0;
    wsel = 2'b11;
    repeat (3) @(negedge clk);
    chk(state == 3'd0 && !clk_ready && !op_rst, "R1", state, 0);
    init_n = 1'b1;
    @(negedge clk);
    init_tail("R2", tap(0));
  endtask

  task automatic t_soft_init(int code);
    wsel = 2'(code);
    @(negedge clk);
    int_init = 1'b1;
    @(negedge clk);
    int_init = 1'b0;
    wsel = 2'(3 - code);
    chk(state == 3'd0, "R4", state, 0);
    @(negedge clk);
    init_tail("R4", tap(code));
  endtask

  task automatic t_stop(int code_run, int code_stop, bit oscs, bit pll,
                        int exp_wait, string req);
    int n;
    bit bad;
    wsel = 2'(code_run);
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(state == 3'd4 && !clk_ready, "R11", state, 4);
    wsel = 2'(code_stop);
    osc_stop_cfg = oscs;
    pll_used = pll;
    repeat (3) @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    count_in(3'd1, 1'b0, n, bad);
    chk(n == exp_wait, req, n, exp_wait);
    chk(state == 3'd3 && clk_ready && !op_rst, "R9", state, 3);
  endtask

  task automatic t_abort();
    wsel = 2'b11;
    @(negedge clk);
    int_init = 1'b1;
    @(negedge clk);
    int_init = 1'b0;
    repeat (6) @(negedge clk);
    chk(state == 3'd1, "R10", state, 1);
    init_n = 1'b0;
    #1;
    chk(state == 3'd0, "R10", state, 0);
    @(negedge clk);
    init_n = 1'b1;
    @(negedge clk);
    init_tail("R10", tap(0));
  endtask

  task automatic t_priority();
    @(negedge clk);
    int_init = 1'b1;
    stop_req = 1'b1;
    @(negedge clk);
    int_init = 1'b0;
    stop_req = 1'b0;
    chk(state == 3'd0, "R12", state, 0);
    @(negedge clk);
    init_tail("R12", tap(2));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_pin_init();                                  // R1 R2 R3
    t_soft_init(2);                                // R4
    t_soft_init(1);                                // R4
    t_stop(0, 3, 1'b1, 1'b1, 1 << TP, "R6");       // R6 PLL longer
    t_stop(3, 0, 1'b1, 1'b1, tap(3), "R6");        // R6 osc longer
    t_stop(1, 3, 1'b1, 1'b0, tap(1), "R7");        // R7 and R5
    t_stop(2, 2, 1'b1, 1'b0, tap(2), "R5");        // R5
    t_stop(3, 3, 1'b0, 1'b1, tap(0), "R8");        // R8
    t_abort();                                     // R10
    wsel = 2'd2;
    @(negedge clk);
    t_priority();                                  // R12
    finish_run();
  end

endmodule